// File: doc/BRIEF.md
# DLL Lock Read Gate

This block sits beside a DDR3 mode-register image. It takes writes of the 13-bit mode register 0 value and keeps the write-recovery field. It decodes that field into a cycle count. When a written value has the DLL-reset bit set, the block starts the lock interval. The DLL-reset bit is never stored, so it always reads back as zero.

While the lock interval runs, READ commands are held back. A held-back READ raises a one-cycle error pulse. Clock enable must stay high for the whole interval. If clock enable drops, the count stops and the block reports an error. When clock enable returns, the count starts again from the full interval. A new DLL reset during an interval also restarts the count from the full interval. After reset, READs stay blocked until the first DLL reset has run to completion.

The lock interval length is the parameter `LOCK_CYCLES`, which defaults to 512. The reset input is asserted asynchronously. Its release passes through `SYNC_STAGES` flops before the internal logic leaves reset.

Top module: `dll_lock_gate`

## Requirements
- R1: A write with `mr_wdata[8]`=1 while `cke` is high starts the lock interval at that clock edge. `rd_allowed` is 0 for the next `LOCK_CYCLES`-1 edges and goes to 1 after the `LOCK_CYCLES`-th edge that follows the write.
- R2: `mr_rdata[8]` always reads 0, even after a write that set it. On a legal write, every other bit reads back as written.
- R3: During reset, and after it, these outputs hold until the first DLL reset completes: `rd_allowed`=0, `err`=0, `mr_rdata`=13'h0200 and `wr_cycles`=5.
- R4: Write recovery in bits 11:9 decodes as follows: 001=5, 010=6, 011=7, 100=8, 101=10 and 110=12 cycles. `wr_cycles` only ever shows one of these values.
- R5: A write with bits 11:9 equal to 000 or 111 pulses `err` for one cycle, starting at the next edge. It leaves the stored write-recovery field and `wr_cycles` unchanged, and the remaining bits are stored as written.
- R6: `rd_issue` equals `rd_cmd` in the same cycle when `rd_allowed` is 1. When `rd_allowed` is 0, a READ gives `rd_issue`=0 and pulses `err` at the next edge.
- R7: If `cke` is low at an edge during the count, `err` pulses once and counting stops for as long as `cke` stays low. The first edge that samples `cke` high reloads the full interval, and `rd_allowed` rises `LOCK_CYCLES` edges after that edge.
- R8: A DLL reset written during a running count restarts the count at the full `LOCK_CYCLES` from that write.
- R9: A DLL reset written while `cke` is low pulses `err` and drops `rd_allowed`. It then waits for `cke` as in R7.
- R10: Once locked, a low `cke` has no effect on `rd_allowed` or `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock-enable level seen by the device |
| mr_wr_en | input | 1 | Mode register write strobe |
| mr_wdata | input | 13 | Mode register write value |
| rd_cmd | input | 1 | READ command request |
| mr_rdata | output | 13 | Stored mode register value, DLL-reset bit always 0 |
| wr_cycles | output | 4 | Decoded write recovery in clock cycles |
| rd_allowed | output | 1 | High when READs may be issued |
| rd_issue | output | 1 | READ command passed on |
| err | output | 1 | One-cycle error pulse |

## Verification
The bench builds the block with `LOCK_CYCLES`=40 and `SYNC_STAGES`=2. With these values, each full lock interval, restart and stall takes only tens of cycles. Every boundary can therefore be sampled exactly one edge before and one edge after the expected rise of `rd_allowed`. The 6-bit counter that results still carries the real terminal-count crossing and the reload paths. The two-stage reset synchroniser adds the latency a real build would have.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;

  localparam int MR_W     = 13;
  localparam int DLL_BIT  = 8;
  localparam int WR_LSB   = 9;
  localparam int WR_MSB   = 11;
  localparam int WR_W     = WR_MSB - WR_LSB + 1;
  localparam int CYC_W    = 4;

  typedef enum logic [1:0] {
    LK_UNLOCKED = 2'd0,
    LK_COUNT    = 2'd1,
    LK_HOLD     = 2'd2,
    LK_LOCKED   = 2'd3
  } lock_state_e;

  function automatic logic wr_code_reserved(input logic [WR_W-1:0] code);
    return (code == '0) || (code == '1);
  endfunction

  function automatic logic [CYC_W-1:0] wr_code_to_cycles(input logic [WR_W-1:0] code);
    logic [CYC_W-1:0] cyc;
    case (code)
      3'b001:  cyc = 4'd5;
      3'b010:  cyc = 4'd6;
      3'b011:  cyc = 4'd7;
      3'b100:  cyc = 4'd8;
      3'b101:  cyc = 4'd10;
      3'b110:  cyc = 4'd12;
      default: cyc = 4'd0;
    endcase
    return cyc;
  endfunction

endpackage

// File: rtl/dll_rst_sync.sv
module dll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dll_mr_store.sv
module dll_mr_store
  import dll_lock_pkg::*;
#(
  parameter logic [MR_W-1:0] MR_RESET = 13'h0200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MR_W-1:0]  wdata,
  output logic [MR_W-1:0]  rdata,
  output logic [CYC_W-1:0] wr_cycles,
  output logic             dll_start,
  output logic             code_bad
);

  logic [MR_W-1:0] mr_q;
  logic [MR_W-1:0] mr_d;
  logic            mr_en;

  // Next-state: bit 8 is never stored; a reserved write-recovery code keeps the old field.
  always_comb begin
    code_bad  = wr_en && wr_code_reserved(wdata[WR_MSB:WR_LSB]);
    dll_start = wr_en && wdata[DLL_BIT];
    mr_en     = wr_en;
    mr_d      = wdata;
    mr_d[DLL_BIT] = 1'b0;
    if (code_bad) mr_d[WR_MSB:WR_LSB] = mr_q[WR_MSB:WR_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mr_q <= MR_RESET;
    else if (mr_en) mr_q <= mr_d;
  end

  assign rdata     = mr_q;
  assign wr_cycles = wr_code_to_cycles(mr_q[WR_MSB:WR_LSB]);

  assert_wr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cycles inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd12});

  assert_keep_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |=> rdata[WR_MSB:WR_LSB] == $past(rdata[WR_MSB:WR_LSB]));

endmodule

// File: rtl/dll_lock_fsm.sv
module dll_lock_fsm
  import dll_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 512,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cke,
  output logic locked,
  output logic cke_fault
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  lock_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cke_fault = 1'b0;
    if (start) begin
      cnt_d = CNT_LOAD;
      if (cke) begin
        state_d = LK_COUNT;
      end else begin
        state_d   = LK_HOLD;
        cke_fault = 1'b1;
      end
    end else begin
      case (state_q)
        LK_COUNT: begin
          if (!cke) begin
            state_d   = LK_HOLD;
            cke_fault = 1'b1;
          end else if (cnt_q == CNT_ONE) begin
            state_d = LK_LOCKED;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        LK_HOLD: begin
          if (cke) begin
            state_d = LK_COUNT;
            cnt_d   = CNT_LOAD;
          end
        end
        default: ;
      endcase
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_UNLOCKED;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign locked = (state_q == LK_LOCKED);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

  assert_lock_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cnt_q) == CNT_ONE);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && cke |=> state_q == LK_COUNT && cnt_q == CNT_LOAD);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LK_HOLD && !cke && !start |=> state_q == LK_HOLD && $stable(cnt_q));

  assert_stay_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !start |=> locked);

endmodule

// File: rtl/dll_lock_gate.sv
module dll_lock_gate
  import dll_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              mr_wr_en,
  input  logic [MR_W-1:0]   mr_wdata,
  input  logic              rd_cmd,
  output logic [MR_W-1:0]   mr_rdata,
  output logic [CYC_W-1:0]  wr_cycles,
  output logic              rd_allowed,
  output logic              rd_issue,
  output logic              err
);

  logic rst_int_n;
  logic dll_start;
  logic code_bad;
  logic locked;
  logic cke_fault;
  logic err_d;
  logic err_q;

  dll_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dll_mr_store u_mr_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (mr_wr_en),
    .wdata     (mr_wdata),
    .rdata     (mr_rdata),
    .wr_cycles (wr_cycles),
    .dll_start (dll_start),
    .code_bad  (code_bad)
  );

  dll_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (dll_start),
    .cke       (cke),
    .locked    (locked),
    .cke_fault (cke_fault)
  );

  // READs pass only once locked; a blocked READ is an error event.
  always_comb begin
    rd_allowed = locked;
    rd_issue   = rd_cmd && locked;
    err_d      = code_bad || cke_fault || (rd_cmd && !locked);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign err = err_q;

  assert_gated_read_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_cmd && !rd_allowed |=> err);

  assert_reserved_code_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mr_wr_en && wr_code_reserved(mr_wdata[WR_MSB:WR_LSB]) |=> err);

  assert_cke_drop_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_allowed == 1'b0 && !cke && mr_wr_en && mr_wdata[DLL_BIT] |=> err && !rd_allowed);

endmodule

// File: tb/dll_lock_gate_bench.sv
`timescale 1ns/1ps
module dll_lock_gate_bench;

  localparam int LOCK = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        mr_wr_en = 1'b0;
  logic [12:0] mr_wdata = '0;
  logic        rd_cmd = 1'b0;
  logic [12:0] mr_rdata;
  logic [3:0]  wr_cycles;
  logic        rd_allowed;
  logic        rd_issue;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dll_lock_gate #(.LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) u_dll_lock_gate (
    .clk(clk), .rst_n(rst_n), .cke(cke), .mr_wr_en(mr_wr_en), .mr_wdata(mr_wdata),
    .rd_cmd(rd_cmd), .mr_rdata(mr_rdata), .wr_cycles(wr_cycles),
    .rd_allowed(rd_allowed), .rd_issue(rd_issue), .err(err)
  );

  // {write data, expected readback, expected cycles, expected err}
  localparam logic [30:0] VEC [8] = '{
    {13'h0400, 13'h0400, 4'd6,  1'b0},
    {13'h0600, 13'h0600, 4'd7,  1'b0},
    {13'h0000, 13'h0600, 4'd7,  1'b1},
    {13'h0800, 13'h0800, 4'd8,  1'b0},
    {13'h0E05, 13'h0805, 4'd8,  1'b1},
    {13'h0A00, 13'h0A00, 4'd10, 1'b0},
    {13'h0C00, 13'h0C00, 4'd12, 1'b0},
    {13'h0203, 13'h0203, 4'd5,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic dll_reset(input logic [12:0] val);
    mr_wr_en = 1'b1;
    mr_wdata = val | 13'h0100;
    tick();
    mr_wr_en = 1'b0;
  endtask

  task automatic expect_lock(input string req);
    repeat (LOCK - 1) tick();
    check(req, rd_allowed, 0);
    tick();
    check(req, rd_allowed, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #12;
    check("R3 reset rd_allowed", rd_allowed, 0);
    check("R3 reset err", err, 0);
    check("R3 reset mr_rdata", mr_rdata, 13'h0200);
    check("R3 reset wr_cycles", wr_cycles, 5);
    #0.5 rst_n = 1'b1;
    repeat (4) tick();
    check("R3 after release rd_allowed", rd_allowed, 0);

    // R6/R3: READ before any DLL reset is blocked
    rd_cmd = 1'b1;
    #1;
    check("R6 gated rd_issue", rd_issue, 0);
    tick();
    rd_cmd = 1'b0;
    check("R6 gated err", err, 1);
    tick();
    check("R6 err one cycle", err, 0);

    // R2/R4/R5 vector table
    for (int i = 0; i < 8; i++) begin
      mr_wr_en = 1'b1;
      mr_wdata = VEC[i][30:18];
      tick();
      mr_wr_en = 1'b0;
      check("R4 wr_cycles", wr_cycles, VEC[i][4:1]);
      check("R2 R5 readback", mr_rdata, VEC[i][17:5]);
      check("R5 err", err, VEC[i][0]);
    end
    tick();

    // R1/R2: DLL reset with write recovery 010
    dll_reset(13'h0400);
    check("R2 bit8 self-clear", mr_rdata, 13'h0400);
    check("R1 gated after start", rd_allowed, 0);
    expect_lock("R1 lock boundary");

    // R6 locked pass-through
    rd_cmd = 1'b1;
    #1;
    check("R6 rd_issue when allowed", rd_issue, 1);
    tick();
    rd_cmd = 1'b0;
    check("R6 no err when allowed", err, 0);

    // R10 cke low after lock
    cke = 1'b0;
    repeat (5) tick();
    check("R10 allowed with cke low", rd_allowed, 1);
    check("R10 no err with cke low", err, 0);
    cke = 1'b1;
    tick();

    // R8 restart during count
    dll_reset(13'h0400);
    check("R1 lock dropped by new reset", rd_allowed, 0);
    repeat (20) tick();
    dll_reset(13'h0400);
    expect_lock("R8 restart boundary");

    // R7 cke drop during count
    dll_reset(13'h0400);
    repeat (10) tick();
    cke = 1'b0;
    tick();
    check("R7 err on cke drop", err, 1);
    tick();
    check("R7 err pulse only", err, 0);
    repeat (LOCK) tick();
    check("R7 stalled while cke low", rd_allowed, 0);
    cke = 1'b1;
    tick();
    expect_lock("R7 reload boundary");

    // R9 DLL reset with cke low
    cke = 1'b0;
    dll_reset(13'h0400);
    check("R9 err", err, 1);
    check("R9 allowed dropped", rd_allowed, 0);
    repeat (3) tick();
    check("R9 waits for cke", rd_allowed, 0);
    cke = 1'b1;
    tick();
    expect_lock("R9 lock after cke");

    // R3 mid-run reset
    rst_n = 1'b0;
    #1;
    check("R3 async reset rd_allowed", rd_allowed, 0);
    check("R3 async reset mr_rdata", mr_rdata, 13'h0200);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R3 stays gated after reset", rd_allowed, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule